// File: doc/BRIEF.md
# Five-Level Single-Carrier Phase Modulator

This block produces the switch commands for a three-phase inverter that reaches five output levels by stacking two three-level stages in series. Every phase owns four switch pairs, and each pair is driven by a true gate signal and a complementary one, so the block has 24 gate outputs in all. Per phase, the block receives an offset-positive duty reference in fixed point. The integer part of the reference names the lower of two neighbouring output levels. Only the fractional part is compared with one triangular carrier that all three phases share. When the fraction is at or above the carrier, the level one step higher is driven.

The chosen level, from 0 (lowest) to 4 (highest), passes through one of six selectable level-to-state patterns. The pattern yields a 4-bit switch code. Several codes give the same output voltage, and each pattern picks among them so that a one-level step flips a single switch pair. The references and the pattern select are sampled once per carrier period, at the carrier's zero point. Dead time, the power stage and the computation of the references are handled elsewhere.

Top module: `pm5_modulator`

## Requirements
- R1: The carrier counts 0,1,…,2^F−1 and then back down to 0, where F is FRAC_W. A full period is 2·(2^F−1) clock cycles. The first count after reset is 0, counting up.
- R2: The per-phase references and the pattern select are captured only in a cycle where the carrier is 0. Changes at any other time have no effect until the next such cycle.
- R3: Each phase reference holds 3 integer bits above FRAC_W fraction bits. Phase 0 sits in the lowest bits of `ref_i`. The driven level is the integer part plus one when the captured fraction ≥ the carrier; otherwise it is the integer part alone.
- R4: A captured integer part of 4 or more drives level 4 for the whole period, whatever the fraction is.
- R5: Select values 0..5 choose patterns P1..P6. Levels 0..4 map to the codes below, written as T1 T2 T3 T4 (T1 = bit 3 of the phase's nibble, phase p using `sw_o[4p+3:4p]`). P1: 0011,0010,0000,1000,1100. P2: 0011,0010,1010,1000,1100. P3: 0011,0010,1010,1110,1100. P4: 0011,1011,1111,1110,1100. P5: 0011,1011,1010,1000,1100. P6: 0011,1011,1010,1110,1100.
- R6: Select values 6 and 7 act as P1.
- R7: For every driven code, T1+T2−T3−T4 equals level−2. A one-level step under an unchanged pattern toggles exactly one switch pair.
- R8: While enabled, every complementary output is the inverse of its true output.
- R9: While `rst` is high at a clock edge, every phase is set to the level-2 (0 V) code of the pattern named by `pat_i` at that time. The carrier also restarts at 0.
- R10: With `en` low, all 24 gate outputs are 0 in the same cycle.
- R11: The switch code is registered. The code seen after an edge comes from the carrier value and the captured reference that were present before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Output enable; low forces all gates low |
| pat_i | input | 3 | Level-to-state pattern select |
| ref_i | input | 3*(3+FRAC_W) | Packed per-phase duty references |
| sw_o | output | 12 | True gate signals, four per phase |
| swn_o | output | 12 | Complementary gate signals |

## Verification
The hardest case to reach from the ports is a reference or pattern change that lands between two carrier zero points, because its effect stays hidden until the next capture. The stimulus changes the references every few cycles, out of step with the 30-cycle period. A cycle-accurate model in the bench then shows that the outputs follow only the values captured at the zero point. Saturation is driven with integer parts of 4, 5 and 7. Reset is applied a second time in the middle of a run, under a pattern whose 0 V code is unusual.

// File: rtl/pm5_pkg.sv
package pm5_pkg;

  localparam int LVL_W   = 3;
  localparam int TOP_LVL = 4;
  localparam int MID_LVL = 2;
  localparam int NPAT    = 6;

  typedef logic [3:0] sw_code_t;
  typedef logic [2:0] pat_sel_t;

  // out-of-range select falls back to the first pattern
  function automatic pat_sel_t norm_sel(input pat_sel_t s);
    return (int'(s) >= NPAT) ? 3'd0 : s;
  endfunction

  // level 0..4 to switch code {T1,T2,T3,T4}
  function automatic sw_code_t lvl_code(input pat_sel_t s, input logic [LVL_W-1:0] lvl);
    sw_code_t c;
    case (lvl)
      3'd0: c = 4'b0011;
      3'd1: c = (s < 3'd3) ? 4'b0010 : 4'b1011;
      3'd2: begin
        case (s)
          3'd0:    c = 4'b0000;
          3'd3:    c = 4'b1111;
          default: c = 4'b1010;
        endcase
      end
      3'd3: c = (s == 3'd2 || s == 3'd3 || s == 3'd5) ? 4'b1110 : 4'b1000;
      default: c = 4'b1100;
    endcase
    return c;
  endfunction

  // signed voltage of a code in units of one cell voltage
  function automatic int code_weight(input sw_code_t c);
    return int'(c[3]) + int'(c[2]) - int'(c[1]) - int'(c[0]);
  endfunction

endpackage

// File: rtl/pm5_carrier.sv
module pm5_carrier #(
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [FRAC_W-1:0] carrier,
  output logic              period_start
);
  localparam logic [FRAC_W-1:0] CMAX = {FRAC_W{1'b1}};

  logic going_up;
  logic past_valid;

  assign period_start = (carrier == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      carrier  <= '0;
      going_up <= 1'b1;
    end else if (going_up) begin
      if (carrier == CMAX) begin
        carrier  <= carrier - 1'b1;
        going_up <= 1'b0;
      end else begin
        carrier <= carrier + 1'b1;
      end
    end else begin
      if (carrier == '0) begin
        carrier  <= carrier + 1'b1;
        going_up <= 1'b1;
      end else begin
        carrier <= carrier - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) past_valid <= 1'b0;
    else     past_valid <= 1'b1;
  end

  // R1: carrier moves by exactly one count each cycle
  p_carrier_step_r1: assert property (@(posedge clk) disable iff (rst)
    past_valid |-> ((carrier == $past(carrier) + 1'b1) || ($past(carrier) == carrier + 1'b1)));

  // R1: the turning points are the ends of the range
  p_carrier_turn_r1: assert property (@(posedge clk) disable iff (rst)
    (past_valid && $past(carrier) == CMAX) |-> (carrier == CMAX - 1'b1));

endmodule

// File: rtl/pm5_phase.sv
module pm5_phase
  import pm5_pkg::*;
#(
  parameter int FRAC_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [FRAC_W-1:0]       carrier,
  input  logic [LVL_W+FRAC_W-1:0] ref_in,
  input  pat_sel_t                sel_live,
  input  pat_sel_t                sel_lat,
  output sw_code_t                code_q
);
  localparam int REF_W = LVL_W + FRAC_W;

  logic [LVL_W-1:0]  lat_int;
  logic [FRAC_W-1:0] lat_frac;
  logic [LVL_W-1:0]  int_sat;
  logic              pick_upper;
  logic [LVL_W-1:0]  lvl_now;
  logic [LVL_W-1:0]  lvl_q;
  pat_sel_t          sel_q;
  logic              past_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_int  <= LVL_W'(MID_LVL);
      lat_frac <= '0;
    end else if (load) begin
      lat_int  <= ref_in[REF_W-1:FRAC_W];
      lat_frac <= ref_in[FRAC_W-1:0];
    end
  end

  assign int_sat    = (int'(lat_int) >= TOP_LVL) ? LVL_W'(TOP_LVL) : lat_int;
  assign pick_upper = (lat_frac >= carrier);
  assign lvl_now    = (int'(int_sat) == TOP_LVL) ? int_sat : int_sat + LVL_W'(pick_upper);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= lvl_code(sel_live, LVL_W'(MID_LVL));
      lvl_q  <= LVL_W'(MID_LVL);
      sel_q  <= sel_live;
    end else begin
      code_q <= lvl_code(sel_lat, lvl_now);
      lvl_q  <= lvl_now;
      sel_q  <= sel_lat;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) past_valid <= 1'b0;
    else     past_valid <= 1'b1;
  end

  // R7: the code's weighted sum matches the level it stands for
  p_code_weight_r7: assert property (@(posedge clk) disable iff (rst)
    code_weight(code_q) == int'(lvl_q) - MID_LVL);

  // R7: one-level step under the same pattern flips a single pair
  p_one_pair_r7: assert property (@(posedge clk) disable iff (rst)
    (past_valid && sel_q == $past(sel_q) &&
     ((lvl_q == $past(lvl_q) + 1'b1) || ($past(lvl_q) == lvl_q + 1'b1)))
    |-> ($countones(code_q ^ $past(code_q)) == 1));

  // R4: saturated integer part holds the top level
  p_saturate_r4: assert property (@(posedge clk) disable iff (rst)
    (int'(lat_int) >= TOP_LVL) |=> (int'(lvl_q) == TOP_LVL));

  // R3: level stays within one step above the captured integer part
  p_level_range_r3: assert property (@(posedge clk) disable iff (rst)
    (past_valid && int'(lat_int) < TOP_LVL && !$past(load))
    |-> (lvl_q == lat_int || lvl_q == lat_int + 1'b1));

endmodule

// File: rtl/pm5_modulator.sv
module pm5_modulator
  import pm5_pkg::*;
#(
  parameter int FRAC_W = 4,
  parameter int NPH    = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            en,
  input  logic [2:0]                      pat_i,
  input  logic [NPH*(LVL_W+FRAC_W)-1:0]   ref_i,
  output logic [NPH*4-1:0]                sw_o,
  output logic [NPH*4-1:0]                swn_o
);
  localparam int REF_W = LVL_W + FRAC_W;
  localparam int GW    = NPH * 4;

  logic [FRAC_W-1:0] carrier;
  logic              period_start;
  pat_sel_t          sel_live;
  pat_sel_t          sel_lat;
  logic [GW-1:0]     code_all;
  logic              past_valid;

  pm5_carrier #(.FRAC_W(FRAC_W)) u_carrier (
    .clk          (clk),
    .rst          (rst),
    .carrier      (carrier),
    .period_start (period_start)
  );

  assign sel_live = norm_sel(pat_i);

  always_ff @(posedge clk) begin
    if (rst)               sel_lat <= sel_live;
    else if (period_start) sel_lat <= sel_live;
  end

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    pm5_phase #(.FRAC_W(FRAC_W)) u_phase (
      .clk      (clk),
      .rst      (rst),
      .load     (period_start),
      .carrier  (carrier),
      .ref_in   (ref_i[p*REF_W +: REF_W]),
      .sel_live (sel_live),
      .sel_lat  (sel_lat),
      .code_q   (code_all[p*4 +: 4])
    );
  end

  assign sw_o  = en ? code_all  : '0;
  assign swn_o = en ? ~code_all : '0;

  always_ff @(posedge clk) begin
    if (rst) past_valid <= 1'b0;
    else     past_valid <= 1'b1;
  end

  // R2: pattern capture happens only at the carrier zero point
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (past_valid && !$past(period_start)) |-> (sel_lat == $past(sel_lat)));

  // R8: complementary outputs mirror the true outputs
  p_complement_r8: assert property (@(posedge clk) disable iff (rst)
    en |-> ((swn_o ^ sw_o) == {GW{1'b1}}));

  // R10: disabled outputs are all low
  p_disable_r10: assert property (@(posedge clk) disable iff (rst)
    !en |-> (sw_o == '0 && swn_o == '0));

  // R6: captured select never names a missing pattern
  p_sel_valid_r6: assert property (@(posedge clk) disable iff (rst)
    int'(sel_lat) < NPAT);

endmodule

// File: tb/tb_pm5_modulator.sv
module tb_pm5_modulator;
  localparam int CLK_PERIOD = 10;
  localparam int F   = 4;
  localparam int NPH = 3;
  localparam int RW  = 3 + F;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               en  = 1'b1;
  logic [2:0]         pat_i = 3'd2;
  logic [NPH*RW-1:0]  ref_i = '0;
  logic [NPH*4-1:0]   sw_o, swn_o;

  pm5_modulator #(.FRAC_W(F), .NPH(NPH)) dut (
    .clk(clk), .rst(rst), .en(en), .pat_i(pat_i), .ref_i(ref_i),
    .sw_o(sw_o), .swn_o(swn_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  string tag = "R9";

  // pattern words: five nibbles, lowest level first from the top nibble
  int pat_word[6] = '{32'h3208C, 32'h32A8C, 32'h32AEC, 32'h3BFEC, 32'h3BA8C, 32'h3BAEC};

  int m_cnt, m_up, m_sel;
  int m_int[NPH], m_frac[NPH], m_lvl[NPH], m_code[NPH];

  function automatic int pick(int sel, int lvl);
    return (pat_word[sel] >> (16 - 4*lvl)) & 15;
  endfunction

  function automatic int sel_of(logic [2:0] s);
    return (int'(s) > 5) ? 0 : int'(s);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_up = 1; m_sel = sel_of(pat_i);
      for (int p = 0; p < NPH; p++) begin
        m_int[p] = 2; m_frac[p] = 0; m_lvl[p] = 2; m_code[p] = pick(m_sel, 2);
      end
    end else begin
      for (int p = 0; p < NPH; p++) begin
        int l;
        l = (m_int[p] > 4) ? 4 : m_int[p];
        if (l < 4 && m_frac[p] >= m_cnt) l = l + 1;
        m_lvl[p]  = l;
        m_code[p] = pick(m_sel, l);
      end
      if (m_cnt == 0) begin
        m_sel = sel_of(pat_i);
        for (int p = 0; p < NPH; p++) begin
          m_int[p]  = int'(ref_i[p*RW +: RW]) >> F;
          m_frac[p] = int'(ref_i[p*RW +: RW]) & ((1 << F) - 1);
        end
      end
      if (m_up == 1) begin
        if (m_cnt == (1 << F) - 1) begin m_cnt = m_cnt - 1; m_up = 0; end
        else m_cnt = m_cnt + 1;
      end else begin
        if (m_cnt == 0) begin m_cnt = 1; m_up = 1; end
        else m_cnt = m_cnt - 1;
      end
    end
  end

  task automatic compare();
    logic [NPH*4-1:0] exp_sw;
    for (int p = 0; p < NPH; p++) exp_sw[p*4 +: 4] = 4'(m_code[p]);
    if (!en) exp_sw = '0;
    checks++;
    if (sw_o !== exp_sw) begin
      errors++;
      $display("FAIL %s: sw_o=%h expected %h at %0t", tag, sw_o, exp_sw, $time);
    end
    checks++;
    if (swn_o !== (en ? ~exp_sw : '0)) begin
      errors++;
      $display("FAIL R8/%s: swn_o=%h expected %h", tag, swn_o, (en ? ~exp_sw : 12'h0));
    end
    if (en) begin
      for (int p = 0; p < NPH; p++) begin
        int w;
        w = int'(sw_o[p*4+3]) + int'(sw_o[p*4+2]) - int'(sw_o[p*4+1]) - int'(sw_o[p*4]);
        checks++;
        if (w != m_lvl[p] - 2) begin
          errors++;
          $display("FAIL R7: phase %0d weight %0d expected %0d", p, w, m_lvl[p] - 2);
        end
      end
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  function automatic logic [RW-1:0] mk(int ip, int fr);
    return RW'((ip << F) | fr);
  endfunction

  task automatic set_refs(int i0, int f0, int i1, int f1, int i2, int f2);
    ref_i = {mk(i2, f2), mk(i1, f1), mk(i0, f0)};
  endtask

  bit timed_out = 0;

  initial begin
    fork
      begin
        // R9: reset state under pattern P3
        set_refs(2, 8, 1, 0, 3, 15);
        run(3);
        @(negedge clk); rst = 1'b0;
        // R1 and R11: carrier shape seen through pulse widths
        tag = "R1";  run(64);
        tag = "R3";  set_refs(0, 3, 1, 12, 3, 6); run(62);
        // R2: references change off the zero point
        tag = "R2";
        for (int k = 0; k < 14; k++) begin
          set_refs(k % 4, (k * 5) % 16, (k + 1) % 4, (k * 3) % 16, (k + 2) % 4, 15 - k);
          pat_i = 3'(k % 6);
          run(7);
        end
        // R4: saturation at and above the top level
        tag = "R4";  set_refs(4, 15, 5, 0, 7, 9); run(62);
        // R5: every pattern over a spread of references
        tag = "R5";
        for (int s = 0; s < 6; s++) begin
          pat_i = 3'(s);
          set_refs(s % 4, 9, (s + 1) % 4, 2, 3 - (s % 4), 14);
          run(31);
        end
        // R6: out-of-range selects
        tag = "R6";
        pat_i = 3'd6; set_refs(1, 7, 2, 7, 0, 7); run(31);
        pat_i = 3'd7; set_refs(2, 11, 1, 4, 3, 1); run(31);
        // R10: enable low, then back
        tag = "R10"; pat_i = 3'd3; en = 1'b0; run(12);
        tag = "R11"; en = 1'b1; set_refs(0, 15, 3, 0, 2, 5); run(45);
        // R9: reset mid-run under P4 (0 V code 1111)
        tag = "R9";  pat_i = 3'd3; rst = 1'b1; run(3);
        rst = 1'b0;
        tag = "R7";  set_refs(1, 10, 2, 1, 3, 13); run(62);
      end
      begin
        repeat (200000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    if (timed_out) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule